// File: doc/BRIEF.md
# Hierarchical Interrupt Tree Controller

The block gathers a large set of interrupt request lines and presents them to a host through a narrow byte-wide register port and a single interrupt output. Lines are grouped eight to a block and blocks eight to a master. Each line carries its own trigger setting: edge or level, with an independent mask per polarity. When a line is triggered it latches a pending bit. Pending bits are folded upward into per-master status bytes and then into one root byte. The host output is raised whenever the root byte is non-zero.

Per-line state is reached indirectly. The host first writes a block number into a select register. It can then read that block's pending byte or its raw line levels, or write a configuration byte that names one line of the block. A typical handler reads the root byte, then the flagged master bytes, then selects each flagged block and reads its pending bits. It acknowledges a line by writing a configuration byte with the clear bit set.

Inputs are asynchronous to the bus clock and pass through a two-stage synchroniser. The line count is a parameter and must be a multiple of eight, with at most 256 lines. The register window starts at a parameterised base address, 0x1BB by default.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset, `host_irq` is low and every register reads zero. Every line starts with both masks set, so it never becomes pending, and its config reads back as 3'b110.
- R2: The register offsets from the base are: root +0, master status 0..3 at +1..+4, block select +5, pending +6, config +7, raw level +8. A read returns data on `bus_rdata` one cycle after the read strobe and 0 in cycles with no read. The block select register reads back the last value written. Addresses outside the window read 0.
- R3: A write to the config offset takes effect only if data bit 7 is 1. Bits 6:4 pick the line within the selected block. Bits 2:0 are stored as {rise-mask, fall-mask, level-select}. Reading the config offset returns {5'b0, stored bits} of line 0 of the selected block.
- R4: With level-select 0 and rise-mask 0, a 0-to-1 input transition makes the line pending. The pending bit is set on the third rising clock edge after the input changes.
- R5: With level-select 0 and fall-mask 0, a 1-to-0 transition makes the line pending. With both masks 0, both directions trigger.
- R6: With level-select 1, rise-mask 0 means active-high and fall-mask 0 means active-low. While the level stays active, the line becomes pending again one cycle after a clear.
- R7: A valid config write with bit 3 set clears the pending bit of the addressed line in that cycle. The clear takes priority over a trigger in the same cycle.
- R8: The pending offset returns the 8 pending bits of the selected block. The raw-level offset returns its 8 synchronised input levels. Line n of the block is bit n.
- R9: Master m status bit b is set when block 8m+b has any pending line. Root bit m+1 is set when master m has any bit set. Root bit 0 always reads 0.
- R10: `host_irq` is high exactly when at least one line is pending.
- R11: When the block select value is at or beyond the number of blocks, the pending, raw-level and config offsets read 0 and config writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read strobe |
| line_in | input | 256 | Asynchronous interrupt request lines |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The trigger logic is driven with single rising and single falling transitions under each mask setting, which separates the rise and fall detectors. Sustained levels are held across clears, which separates level mode from edge mode through re-assertion. Lines in blocks under different masters show whether the summary tree routes each block to the right master bit and root bit, and out-of-range selects probe the read mux. A long random phase then toggles lines, rewrites configs and reads every offset. It is compared each cycle against a behavioural model, which catches ordering slips such as clear-versus-set priority and the use of old versus new config.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int LINES_PER_BLK = 8;
  localparam int BLKS_PER_MST  = 8;
  localparam int ADDR_W        = 10;
  localparam int DATA_W        = 8;
  localparam int MAX_MST       = 4;

  // register offsets from the base address
  localparam int OFS_ROOT = 0;
  localparam int OFS_MST0 = 1;
  localparam int OFS_SEL  = 5;
  localparam int OFS_PEND = 6;
  localparam int OFS_CFG  = 7;
  localparam int OFS_RAW  = 8;
  localparam int OFS_LAST = 8;

  // config byte fields
  localparam int CFG_CLR_BIT = 3;
  localparam int CFG_WEN_BIT = 7;
  localparam int CFG_LN_LSB  = 4;

  typedef struct packed {
    logic mask_rise;
    logic mask_fall;
    logic lvl_sel;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{mask_rise: 1'b1, mask_fall: 1'b1, lvl_sel: 1'b0};
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tree_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_i,
  input  logic      wr_hit_i,
  input  line_cfg_t wr_cfg_i,
  input  logic      wr_clr_i,
  output logic      pend_o,
  output logic      level_o,
  output line_cfg_t cfg_o
);
  logic [1:0] sync_q, sync_d;
  logic       prev_q, prev_d;
  logic       pend_q, pend_d;
  line_cfg_t  cfg_q, cfg_d;
  logic       level, rise, fall, trig;

  assign level = sync_q[1];

  always_comb begin
    rise   = level & ~prev_q;
    fall   = ~level & prev_q;
    if (cfg_q.lvl_sel) begin
      trig = (~cfg_q.mask_rise & level) | (~cfg_q.mask_fall & ~level);
    end else begin
      trig = (~cfg_q.mask_rise & rise) | (~cfg_q.mask_fall & fall);
    end
    sync_d = {sync_q[0], line_i};
    prev_d = level;
    if (wr_hit_i && wr_clr_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q | trig;
    end
    cfg_d = wr_hit_i ? wr_cfg_i : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cfg_q  <= CFG_RESET;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      pend_q <= pend_d;
      cfg_q  <= cfg_d;
    end
  end

  assign pend_o  = pend_q;
  assign level_o = level;
  assign cfg_o   = cfg_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && wr_clr_i) |=> !pend_q); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mask_rise && cfg_q.mask_fall && !pend_q) |=> !pend_q); // R1
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.lvl_sel && !cfg_q.mask_rise && level && !prev_q && !wr_hit_i) |=> pend_q); // R4
endmodule

// File: rtl/irq_summary_tree.sv
module irq_summary_tree
  import irq_tree_pkg::*;
#(
  parameter int NUM_BLK = 32
) (
  input  logic [NUM_BLK*LINES_PER_BLK-1:0] pend_i,
  output logic [MAX_MST*8-1:0]             mst_o,
  output logic [7:0]                       root_o
);
  localparam int NUM_MST = (NUM_BLK + BLKS_PER_MST - 1) / BLKS_PER_MST;

  logic [NUM_BLK-1:0] blk_any;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk_any[b] = |pend_i[b*LINES_PER_BLK +: LINES_PER_BLK];
  end

  for (genvar m = 0; m < MAX_MST; m++) begin : g_mst
    for (genvar j = 0; j < BLKS_PER_MST; j++) begin : g_bit
      if (m < NUM_MST && (m*BLKS_PER_MST + j) < NUM_BLK) begin : g_used
        assign mst_o[m*8 + j] = blk_any[m*BLKS_PER_MST + j];
      end else begin : g_unused
        assign mst_o[m*8 + j] = 1'b0;
      end
    end
  end

  always_comb begin
    root_o = '0;
    for (int m = 0; m < MAX_MST; m++) begin
      root_o[m+1] = |mst_o[m*8 +: 8];
    end
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_tree_pkg::*;
#(
  parameter int              NUM_BLK   = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  input  logic [NUM_BLK*LINES_PER_BLK-1:0] pend_i,
  input  logic [NUM_BLK*LINES_PER_BLK-1:0] level_i,
  input  logic [NUM_BLK*3-1:0]             cfg0_i,
  input  logic [MAX_MST*8-1:0]             mst_i,
  input  logic [7:0]                       root_i,
  output logic [7:0]                       blk_sel_o,
  output logic                             cfg_wr_o
);
  logic [ADDR_W-1:0] off;
  logic              in_map;
  logic [7:0]        sel_q, sel_d;
  logic [7:0]        rd_val;
  logic [7:0]        rdata_q, rdata_d;
  logic              sel_ok;

  always_comb begin
    off    = bus_addr - BASE_ADDR;
    in_map = (bus_addr >= BASE_ADDR) && (off <= ADDR_W'(OFS_LAST));
    sel_ok = (32'(sel_q) < NUM_BLK);
    rd_val = '0;
    if (in_map) begin
      if (off == ADDR_W'(OFS_ROOT)) rd_val = root_i;
      for (int m = 0; m < MAX_MST; m++) begin
        if (off == ADDR_W'(OFS_MST0 + m)) rd_val = mst_i[m*8 +: 8];
      end
      if (off == ADDR_W'(OFS_SEL)) rd_val = sel_q;
      for (int b = 0; b < NUM_BLK; b++) begin
        if (32'(sel_q) == b) begin
          if (off == ADDR_W'(OFS_PEND)) rd_val = pend_i[b*LINES_PER_BLK +: LINES_PER_BLK];
          if (off == ADDR_W'(OFS_RAW))  rd_val = level_i[b*LINES_PER_BLK +: LINES_PER_BLK];
          if (off == ADDR_W'(OFS_CFG))  rd_val = {5'b0, cfg0_i[b*3 +: 3]};
        end
      end
    end
    rdata_d  = bus_rd ? rd_val : '0;
    sel_d    = (bus_wr && in_map && off == ADDR_W'(OFS_SEL)) ? bus_wdata : sel_q;
    cfg_wr_o = bus_wr && in_map && (off == ADDR_W'(OFS_CFG)) && bus_wdata[CFG_WEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      sel_q   <= sel_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign blk_sel_o = sel_q;

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_map && !sel_ok && (off == ADDR_W'(OFS_PEND) || off == ADDR_W'(OFS_RAW)))
    |=> (bus_rdata == 8'h00)); // R11
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int                NUM_LINES = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  output logic                 host_irq
);
  localparam int NUM_BLK = NUM_LINES / LINES_PER_BLK;

  logic [1:0]           rst_q;
  logic                 rst_ni;
  logic [NUM_LINES-1:0] pend_vec, level_vec, hit_vec;
  logic [NUM_BLK*3-1:0] cfg0_vec;
  logic [MAX_MST*8-1:0] mst_vec;
  logic [7:0]           root_val;
  logic [7:0]           blk_sel;
  logic                 cfg_wr;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    line_cfg_t cfg_n;
    assign hit_vec[n] = cfg_wr
                     && (32'(blk_sel) == n / LINES_PER_BLK)
                     && (32'(bus_wdata[CFG_LN_LSB +: 3]) == n % LINES_PER_BLK);
    irq_line_cell i_cell (
      .clk      (clk),
      .rst_n    (rst_ni),
      .line_i   (line_in[n]),
      .wr_hit_i (hit_vec[n]),
      .wr_cfg_i (line_cfg_t'(bus_wdata[2:0])),
      .wr_clr_i (bus_wdata[CFG_CLR_BIT]),
      .pend_o   (pend_vec[n]),
      .level_o  (level_vec[n]),
      .cfg_o    (cfg_n)
    );
    if (n % LINES_PER_BLK == 0) begin : g_cfg0
      assign cfg0_vec[(n/LINES_PER_BLK)*3 +: 3] = cfg_n;
    end
  end

  irq_summary_tree #(.NUM_BLK(NUM_BLK)) i_tree (
    .pend_i (pend_vec),
    .mst_o  (mst_vec),
    .root_o (root_val)
  );

  irq_reg_port #(.NUM_BLK(NUM_BLK), .BASE_ADDR(BASE_ADDR)) i_port (
    .clk       (clk),
    .rst_n     (rst_ni),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_i    (pend_vec),
    .level_i   (level_vec),
    .cfg0_i    (cfg0_vec),
    .mst_i     (mst_vec),
    .root_i    (root_val),
    .blk_sel_o (blk_sel),
    .cfg_wr_o  (cfg_wr)
  );

  assign host_irq = |root_val;

  AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_ni)
    host_irq == (|pend_vec)); // R10
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
endmodule

// File: tb/test_irq_tree_ctrl.sv
module test_irq_tree_ctrl;
  localparam int NL   = 256;
  localparam int NB   = NL / 8;
  localparam int BASE = 'h1BB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [NL-1:0] line_in = '0;
  logic         host_irq;

  int vectors = 0;
  int fails   = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_tree_ctrl i_irq_tree_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_in(line_in), .host_irq(host_irq)
  );

  // behavioural reference model
  bit [NL-1:0] m_s0, m_s1, m_prev, m_pend;
  bit [2:0]    m_cfg [NL];
  int          m_sel;
  bit [7:0]    m_rdata;

  function automatic bit [7:0] ref_read(int a);
    bit [7:0] v = 0;
    int o = a - BASE;
    if (a < BASE || o > 8) return 0;
    if (o == 0) begin
      for (int m = 0; m < 4; m++) if (m_pend[m*64 +: 64] != 0) v[m+1] = 1'b1;
    end else if (o <= 4) begin
      for (int j = 0; j < 8; j++) if (m_pend[(o-1)*64 + j*8 +: 8] != 0) v[j] = 1'b1;
    end else if (o == 5) begin
      v = 8'(m_sel);
    end else if (m_sel < NB) begin
      if (o == 6) v = m_pend[m_sel*8 +: 8];
      if (o == 8) v = m_s1[m_sel*8 +: 8];
      if (o == 7) v = {5'b0, m_cfg[m_sel*8]};
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s0 = '0; m_s1 = '0; m_prev = '0; m_pend = '0;
      for (int i = 0; i < NL; i++) m_cfg[i] = 3'b110;
      m_sel = 0; m_rdata = 0;
    end else begin
      int ln;
      bit trig, lvl, mr, mf, act;
      m_rdata = bus_rd ? ref_read(int'(bus_addr)) : 8'h00;
      ln = -1;
      if (bus_wr && int'(bus_addr) == BASE + 7 && bus_wdata[7] && m_sel < NB)
        ln = m_sel * 8 + int'(bus_wdata[6:4]);
      for (int n = 0; n < NL; n++) begin
        lvl = m_cfg[n][0]; mf = m_cfg[n][1]; mr = m_cfg[n][2];
        if (lvl) trig = (!mr && m_s1[n]) || (!mf && !m_s1[n]);
        else     trig = (!mr && m_s1[n] && !m_prev[n]) || (!mf && !m_s1[n] && m_prev[n]);
        act = (n == ln);
        if (act && bus_wdata[3]) m_pend[n] = 1'b0;
        else if (trig)           m_pend[n] = 1'b1;
      end
      if (ln >= 0) m_cfg[ln] = bus_wdata[2:0];
      if (bus_wr && int'(bus_addr) == BASE + 5) m_sel = int'(bus_wdata);
      m_prev = m_s1; m_s1 = m_s0; m_s0 = line_in;
    end
  end

  // comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (host_irq !== (m_pend != 0)) begin
        fails++;
        $display("FAIL %s host_irq actual=%b expected=%b", cur_req, host_irq, (m_pend != 0));
      end
      vectors++;
      if (bus_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s bus_rdata actual=%h expected=%h", cur_req, bus_rdata, m_rdata);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int o, bit [7:0] d);
    @(negedge clk);
    bus_addr = 10'(BASE + o); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(int o);
    @(negedge clk);
    bus_addr = 10'(BASE + o); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_all();
    for (int o = 0; o < 9; o++) rd_reg(o);
  endtask

  task automatic set_cfg(int line, bit [3:0] bits);
    wr_reg(5, 8'(line / 8));
    wr_reg(7, {1'b1, 3'(line % 8), bits});
  endtask

  initial begin
    // R1: reset state
    idle(3);
    vectors++;
    if (host_irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 host_irq in reset actual=%b expected=0", host_irq);
    end
    rst_n = 1'b1;
    idle(5);
    cur_req = "R1";
    rd_all();
    line_in[3] = 1'b1; idle(6); rd_reg(6); line_in[3] = 1'b0; idle(4);

    // R2: window and select register
    cur_req = "R2";
    wr_reg(5, 8'd5); rd_reg(5);
    @(negedge clk); bus_addr = 10'(BASE - 1); bus_rd = 1'b1;
    @(negedge clk); bus_addr = 10'(BASE + 9);
    @(negedge clk); bus_rd = 1'b0; idle(2);

    // R3: config write enable and readback
    cur_req = "R3";
    wr_reg(7, 8'h80); rd_reg(7);
    wr_reg(7, 8'h06); rd_reg(7);
    wr_reg(7, 8'hB5); rd_reg(7);
    wr_reg(7, 8'h83); rd_reg(7);

    // R4: rising edge on line 43 (block 5 bit 3)
    cur_req = "R4";
    set_cfg(43, 4'b0010);
    line_in[43] = 1'b1; idle(1); rd_reg(6); idle(3); rd_reg(6); rd_reg(8);

    // R7: clear
    cur_req = "R7";
    set_cfg(43, 4'b1010); rd_reg(6); idle(3);
    // R5: falling only, then both edges
    cur_req = "R5";
    set_cfg(43, 4'b0100);
    line_in[43] = 1'b0; idle(5); rd_reg(6);
    set_cfg(43, 4'b1000);
    line_in[43] = 1'b1; idle(5); rd_reg(6);
    set_cfg(43, 4'b1000);
    line_in[43] = 1'b0; idle(5); rd_reg(6);
    set_cfg(43, 4'b1110);

    // R6: level high, level low, re-assert after clear
    cur_req = "R6";
    line_in[43] = 1'b1; idle(4);
    set_cfg(43, 4'b0011); idle(2); rd_reg(6);
    wr_reg(7, 8'hBB); rd_reg(6); rd_reg(6);
    line_in[43] = 1'b0; idle(4); wr_reg(7, 8'hBB); idle(2); rd_reg(6);
    set_cfg(43, 4'b0101); idle(2); rd_reg(6);
    set_cfg(43, 4'b1110); idle(2);

    // R8, R9, R10: lines under several masters
    cur_req = "R9";
    set_cfg(9, 4'b0010); set_cfg(200, 4'b0010); set_cfg(255, 4'b0100);
    line_in[9] = 1'b1; line_in[200] = 1'b1; line_in[255] = 1'b1; idle(5);
    line_in[255] = 1'b0; idle(5);
    rd_all();
    cur_req = "R8";
    wr_reg(5, 8'd25); rd_reg(6); rd_reg(8);
    wr_reg(5, 8'd31); rd_reg(6); rd_reg(8);
    cur_req = "R10";
    set_cfg(9, 4'b1110); set_cfg(200, 4'b1110); rd_reg(0);
    set_cfg(255, 4'b1110); rd_reg(0); idle(2);

    // R11: select out of range
    cur_req = "R11";
    wr_reg(5, 8'd40); rd_reg(6); rd_reg(7); rd_reg(8);
    wr_reg(7, 8'h88); wr_reg(5, 8'd32); rd_reg(6); rd_reg(5);

    // random phase against the model
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      int c = $urandom_range(0, 9);
      if (c < 3) line_in[$urandom_range(0, NL-1)] ^= 1'b1;
      else if (c < 5) set_cfg($urandom_range(0, NL-1), 4'($urandom_range(0, 15)));
      else if (c < 6) wr_reg(5, 8'($urandom_range(0, 35)));
      else if (c < 9) rd_reg($urandom_range(0, 9));
      else wr_reg(7, 8'($urandom));
    end
    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule